// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Datapath with Store Rounding

This block is the arithmetic core of a signal-processing engine. Every clock cycle it takes two signed fractional operands (Q1.(DW-1)) and forms their full-precision product, scaled into Q1.(2DW-1). A 3-bit operation code then either adds that product into a wide accumulator, subtracts it, loads it in place of the old sum, clears the sum, or leaves the sum alone. The accumulator carries GUARD extra integer bits, so that long sums can exceed the fractional range without losing information.

A combinational store path turns the accumulator back into a DW-bit word. It rounds with one of three selectable modes and clamps to the word's limits instead of wrapping. A sticky overflow flag records any clamp, either on the store path or in the accumulator itself, and keeps it until the sum is cleared. The default widths are 16-bit operands, a 32-bit product and a 40-bit accumulator.

Top module: `fxmac_core`

## Requirements
- R1: A synchronous active-low reset sets the accumulator to 0 and the overflow flag to 0, so the stored word reads 0.
- R2: The product is 2*a*b as a signed 2DW-bit value, that is the raw product shifted left by one. When both operands are -2^(DW-1), the product is clamped to 2^(2DW-1)-1. Op code 2 (load) replaces the accumulator with this product, sign-extended.
- R3: Op code 3 (accumulate) adds the sign-extended product to the accumulator. A new operand pair is taken every cycle, and the result is visible on acc_o after the next rising edge.
- R4: Op code 4 (subtract) subtracts the sign-extended product from the accumulator.
- R5: Op code 1 (clear) sets the accumulator to 0 and clears the overflow flag. Op code 0 and the unused codes 5, 6 and 7 leave the accumulator unchanged.
- R6: Rounding mode 0 (truncate) gives floor(acc / 2^DW), which drops the low DW accumulator bits.
- R7: Rounding mode 1 (nearest) adds one to the truncated value when the dropped bits are at least one half, so an exact half goes toward plus infinity.
- R8: Rounding mode 2 (convergent), and mode 3 which behaves the same, adds one when the dropped bits exceed one half. On an exact half it adds one only when the truncated value is odd, so the result ends up even.
- R9: When the rounded value lies outside the word range, word_o is 2^(DW-1)-1 for values above it and -2^(DW-1) for values below it.
- R10: If accumulate or subtract would leave the accumulator range, the accumulator is set to its most positive or most negative value, following the true sign of the result.
- R11: The overflow flag is set at the rising edge after the store path saturates, or at the edge where the accumulator clamps. It stays set through every op except clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 3 | Operation: 0 hold, 1 clear, 2 load, 3 accumulate, 4 subtract, 5-7 hold |
| rnd_i | input | 2 | Store rounding: 0 truncate, 1 nearest, 2 or 3 convergent |
| a_i | input | DW | Signed Q1.(DW-1) operand |
| b_i | input | DW | Signed Q1.(DW-1) operand |
| acc_o | output | 2*DW+GUARD | Accumulator value, Q(GUARD+1).(2DW-1) |
| word_o | output | DW | Rounded and saturated accumulator, Q1.(DW-1) |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
An operation presented before a rising edge shows on acc_o after that edge. word_o follows acc_o and rnd_i with no register delay. The overflow flag lags the store path by one more edge, while an accumulator clamp appears on the flag at the same edge as the clamp. The bench drives inputs on falling edges. It samples acc_o and word_o on the next falling edge, switches rnd_i between samples of the same accumulator, and reads the flag only after one further hold cycle. Expected values come from fixed constants in the vector table and from a rounding model written from R6 to R9.

// File: rtl/fxmac_pkg.sv
// Shared encodings for the fixed-point MAC datapath.
// Assumes op and rounding codes are driven as plain vectors by the caller.
package fxmac_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_CLR  = 3'd1,
        OP_LOAD = 3'd2,
        OP_MAC  = 3'd3,
        OP_MSU  = 3'd4
    } mac_op_e;

    typedef enum logic [1:0] {
        RND_TRUNC = 2'd0,
        RND_NEAR  = 2'd1,
        RND_CONV  = 2'd2,
        RND_CONV2 = 2'd3
    } rnd_mode_e;

endpackage

// File: rtl/fxmac_mult.sv
// Fractional multiplier: forms the full 2*DW product of two Q1.(DW-1)
// operands and shifts it left once to drop the duplicated sign bit.
// Assumes DW >= 2. The single unrepresentable case (-1 * -1) clamps.
module fxmac_mult #(
    parameter int DW = 16
) (
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   b_i,
    output logic [2*DW-1:0] prod_o
);
    localparam int PW = 2 * DW;
    localparam logic [DW-1:0] OPND_MIN = {1'b1, {(DW-1){1'b0}}};
    localparam logic [PW-1:0] PROD_MAX = {1'b0, {(PW-1){1'b1}}};

    logic signed [PW-1:0] raw;
    logic                 both_min;

    // Signed multiply, scale to Q1.(PW-1), clamp the -1 * -1 corner.
    always_comb begin
        raw      = PW'($signed(a_i)) * PW'($signed(b_i));
        both_min = (a_i == OPND_MIN) && (b_i == OPND_MIN);
        prod_o   = both_min ? PROD_MAX : (raw <<< 1);
    end

endmodule

// File: rtl/fxmac_acc.sv
// Guarded accumulator: holds, clears, loads, adds or subtracts the
// product each cycle. On leaving its range it clamps to the nearer
// limit and pulses ovf_o for that cycle.
// Assumes the product is a signed 2*DW value and GUARD >= 1.
module fxmac_acc #(
    parameter int DW    = 16,
    parameter int GUARD = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               op_i,
    input  logic [2*DW-1:0]          prod_i,
    output logic [2*DW+GUARD-1:0]    acc_o,
    output logic                     ovf_o
);
    import fxmac_pkg::*;

    localparam int PW = 2 * DW;
    localparam int AW = PW + GUARD;
    localparam logic [AW-1:0] ACC_MAX = {1'b0, {(AW-1){1'b1}}};
    localparam logic [AW-1:0] ACC_MIN = {1'b1, {(AW-1){1'b0}}};

    logic [AW-1:0] acc_q;
    logic [AW-1:0] acc_d;
    logic [AW:0]   ext_acc;
    logic [AW:0]   ext_prod;
    logic [AW:0]   sum;
    logic          arith;

    // Next accumulator value, with a one-bit-wider sum for the range check.
    always_comb begin
        ext_acc  = {acc_q[AW-1], acc_q};
        ext_prod = {{(GUARD+1){prod_i[PW-1]}}, prod_i};
        sum      = ext_acc;
        arith    = 1'b0;
        acc_d    = acc_q;
        ovf_o    = 1'b0;
        case (op_i)
            OP_CLR:  acc_d = '0;
            OP_LOAD: acc_d = ext_prod[AW-1:0];
            OP_MAC:  begin sum = ext_acc + ext_prod; arith = 1'b1; end
            OP_MSU:  begin sum = ext_acc - ext_prod; arith = 1'b1; end
            default: acc_d = acc_q;
        endcase
        if (arith) begin
            if (sum[AW] != sum[AW-1]) begin
                ovf_o = 1'b1;
                acc_d = sum[AW] ? ACC_MIN : ACC_MAX;
            end else begin
                acc_d = sum[AW-1:0];
            end
        end
    end

    // Accumulator register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc_o = acc_q;

    AST_ACC_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (acc_o == ACC_MAX || acc_o == ACC_MIN)); // R10

endmodule

// File: rtl/fxmac_round.sv
// Store path: reduces the accumulator to a DW-bit Q1.(DW-1) word by
// dropping the low DW bits under the selected rounding mode, then
// clamping to the word range. sat_o is high whenever the clamp acts.
// Purely combinational; assumes DW >= 2 and GUARD >= 1.
module fxmac_round #(
    parameter int DW    = 16,
    parameter int GUARD = 8
) (
    input  logic [2*DW+GUARD-1:0] acc_i,
    input  logic [1:0]            rnd_i,
    output logic [DW-1:0]         word_o,
    output logic                  sat_o
);
    import fxmac_pkg::*;

    localparam int AW = 2 * DW + GUARD;
    localparam int HW = AW - DW;
    localparam logic [DW-1:0] WORD_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] WORD_MIN = {1'b1, {(DW-1){1'b0}}};

    logic [HW-1:0] hi;
    logic          half;
    logic          rest_nz;
    logic          inc;
    logic [HW:0]   rsum;
    logic          fits;

    // Round increment per mode, then range check and clamp.
    always_comb begin
        hi      = acc_i[AW-1:DW];
        half    = acc_i[DW-1];
        rest_nz = |acc_i[DW-2:0];
        case (rnd_i)
            RND_TRUNC: inc = 1'b0;
            RND_NEAR:  inc = half;
            default:   inc = half & (rest_nz | hi[0]);
        endcase
        rsum   = {hi[HW-1], hi} + {{HW{1'b0}}, inc};
        fits   = (rsum[HW:DW-1] == {(HW-DW+2){rsum[HW]}});
        sat_o  = !fits;
        word_o = fits ? rsum[DW-1:0] : (rsum[HW] ? WORD_MIN : WORD_MAX);
    end

endmodule

// File: rtl/fxmac_core.sv
// Fixed-point MAC datapath top: multiplier, guarded accumulator and
// rounding store path, plus the sticky overflow flag. One operation
// per cycle; word_o follows acc_o combinationally.
// Assumes DW >= 2, GUARD >= 1, synchronous active-low reset.
module fxmac_core #(
    parameter int DW    = 16,
    parameter int GUARD = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               op_i,
    input  logic [1:0]               rnd_i,
    input  logic [DW-1:0]            a_i,
    input  logic [DW-1:0]            b_i,
    output logic [2*DW+GUARD-1:0]    acc_o,
    output logic [DW-1:0]            word_o,
    output logic                     ovf_o
);
    import fxmac_pkg::*;

    localparam int PW = 2 * DW;
    localparam int AW = PW + GUARD;
    localparam logic [DW-1:0] WORD_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] WORD_MIN = {1'b1, {(DW-1){1'b0}}};

    logic [PW-1:0] prod;
    logic [AW-1:0] prod_ext;
    logic          acc_ovf;
    logic          store_sat;
    logic          flag_q;

    fxmac_mult #(.DW(DW)) u_mult (
        .a_i    (a_i),
        .b_i    (b_i),
        .prod_o (prod)
    );

    fxmac_acc #(.DW(DW), .GUARD(GUARD)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (op_i),
        .prod_i (prod),
        .acc_o  (acc_o),
        .ovf_o  (acc_ovf)
    );

    fxmac_round #(.DW(DW), .GUARD(GUARD)) u_round (
        .acc_i  (acc_o),
        .rnd_i  (rnd_i),
        .word_o (word_o),
        .sat_o  (store_sat)
    );

    assign prod_ext = {{GUARD{prod[PW-1]}}, prod};

    // Sticky overflow flag: clear op wins, otherwise collect any clamp.
    always_ff @(posedge clk) begin
        if (!rst_n)                flag_q <= 1'b0;
        else if (op_i == OP_CLR)   flag_q <= 1'b0;
        else                       flag_q <= flag_q | acc_ovf | store_sat;
    end

    assign ovf_o = flag_q;

    AST_LOAD_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_LOAD) |=> (acc_o == $past(prod_ext))); // R2
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CLR) |=> (acc_o == '0 && !ovf_o)); // R5
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_NOP || op_i > OP_MSU) |=> $stable(acc_o)); // R5
    AST_WORD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        store_sat |-> (word_o == WORD_MAX || word_o == WORD_MIN)); // R9
    AST_FLAG_ON_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        ((store_sat || acc_ovf) && op_i != OP_CLR) |=> ovf_o); // R11
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && op_i != OP_CLR) |=> ovf_o); // R11

endmodule

// File: tb/fxmac_core_bench.sv
`timescale 1ns/1ps
module fxmac_core_bench;
    localparam int DW = 16;
    localparam int GUARD = 8;
    localparam int AW = 2 * DW + GUARD;
    localparam logic [2:0] C_NOP = 3'd0, C_CLR = 3'd1, C_LOAD = 3'd2,
                           C_MAC = 3'd3, C_MSU = 3'd4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op_r = 3'd0;
    logic [1:0]    rnd_r = 2'd0;
    logic [DW-1:0] a_r = '0;
    logic [DW-1:0] b_r = '0;
    logic [AW-1:0] acc_w;
    logic [DW-1:0] word_w;
    logic          ovf_w;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fxmac_core #(.DW(DW), .GUARD(GUARD)) u_fxmac_core (
        .clk(clk), .rst_n(rst_n), .op_i(op_r), .rnd_i(rnd_r),
        .a_i(a_r), .b_i(b_r), .acc_o(acc_w), .word_o(word_w), .ovf_o(ovf_w)
    );

    typedef struct packed {
        logic [2:0]         op;
        logic signed [15:0] a;
        logic signed [15:0] b;
        logic [1:0]         rnd;
        logic signed [63:0] acc;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd2,  16'sd16384,  16'sd16384, 2'd0,  64'sd536870912},
        '{3'd3,  16'sd16384, -16'sd16384, 2'd1,  64'sd0},
        '{3'd3,  16'sd12345,  16'sd3,     2'd2,  64'sd74070},
        '{3'd4,  16'sd100,    16'sd200,   2'd1,  64'sd34070},
        '{3'd0,  16'sd7,      16'sd7,     2'd0,  64'sd34070},
        '{3'd2, -16'sd32768,  16'sd16384, 2'd2, -64'sd1073741824},
        '{3'd3, -16'sd32768, -16'sd32768, 2'd1,  64'sd1073741823},
        '{3'd1,  16'sd5,      16'sd5,     2'd0,  64'sd0}
    };

    // Store-path model built from the rounding and saturation rules.
    function automatic longint ref_word(longint acc, int mode);
        longint hi, low, r;
        hi  = acc >>> 16;
        low = acc - (hi <<< 16);
        if (mode == 0)      r = hi;
        else if (mode == 1) r = hi + ((low >= 32768) ? 1 : 0);
        else                r = hi + (((low > 32768) || (low == 32768 && (hi & 1) != 0)) ? 1 : 0);
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    function automatic string tag_for(logic [2:0] op);
        case (op)
            3'd2: return "R2";
            3'd3: return "R3";
            3'd4: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply one op at a falling edge; return at the next falling edge.
    task automatic do_op(logic [2:0] op, int a, int b);
        op_r = op; a_r = DW'(a); b_r = DW'(b);
        @(negedge clk);
        op_r = C_NOP;
    endtask

    function automatic longint acc_s();
        return longint'($signed(acc_w));
    endfunction

    function automatic longint word_s();
        return longint'($signed(word_w));
    endfunction

    task automatic rnd_check(string req, int mode, longint exp);
        rnd_r = 2'(mode);
        #0.5;
        chk(req, word_s(), exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with a load presented during reset
        op_r = C_LOAD; a_r = 16'd1000; b_r = 16'd1000;
        repeat (3) @(negedge clk);
        chk("R1 acc", acc_s(), 0);
        chk("R1 flag", longint'(ovf_w), 0);
        chk("R1 word", word_s(), 0);
        op_r = C_NOP;
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2 R3 R4 R5 main function
        for (int i = 0; i < 8; i++) begin
            rnd_r = VECS[i].rnd;
            do_op(VECS[i].op, int'(VECS[i].a), int'(VECS[i].b));
            chk(tag_for(VECS[i].op), acc_s(), longint'(VECS[i].acc));
            chk("R6/R7/R8 table word", word_s(), ref_word(longint'(VECS[i].acc), int'(VECS[i].rnd)));
        end

        // R2: -1 * -1 clamps to the largest product
        do_op(C_LOAD, -32768, -32768);
        chk("R2 min*min", acc_s(), 64'sd2147483647);

        // R6 R7 R8: exact half with odd truncated value (3.5)
        do_op(C_LOAD, 112, 1024);
        rnd_check("R6 trunc 3.5", 0, 3);
        rnd_check("R7 near 3.5", 1, 4);
        rnd_check("R8 conv 3.5", 2, 4);
        // exact half with even truncated value (2.5)
        do_op(C_LOAD, 80, 1024);
        rnd_check("R6 trunc 2.5", 0, 2);
        rnd_check("R7 near 2.5", 1, 3);
        rnd_check("R8 conv 2.5", 2, 2);
        rnd_check("R8 mode3 2.5", 3, 2);
        // negative exact half (-2.5)
        do_op(C_LOAD, -80, 1024);
        rnd_check("R6 trunc -2.5", 0, -3);
        rnd_check("R7 near -2.5", 1, -2);
        rnd_check("R8 conv -2.5", 2, -2);
        // just above half
        do_op(C_LOAD, 3, 27307);
        rnd_check("R8 conv above half", 2, 3);
        rnd_check("R6 trunc above half", 0, 2);

        // R5: unused codes hold the accumulator
        do_op(3'd6, 9, 9);
        chk("R5 op6 hold", acc_s(), 64'sd163842);
        do_op(3'd7, 9, 9);
        chk("R5 op7 hold", acc_s(), 64'sd163842);
        chk("R11 flag still clear", longint'(ovf_w), 0);

        // R9: store saturation positive, and flag one edge later
        rnd_r = 2'd0;
        do_op(C_LOAD, -32768, -32768);
        rnd_check("R9 trunc no clamp", 0, 32767);
        rnd_check("R9 near clamps", 1, 32767);
        do_op(C_NOP, 0, 0);
        chk("R11 flag after store clamp", longint'(ovf_w), 1);
        // R11: a non-clear op keeps the flag
        rnd_r = 2'd0;
        do_op(C_LOAD, 1, 1);
        do_op(C_NOP, 0, 0);
        chk("R11 sticky", longint'(ovf_w), 1);
        chk("R11 word unclamped", word_s(), 0);
        // R5: clear clears the flag
        do_op(C_CLR, 0, 0);
        chk("R5 clear acc", acc_s(), 0);
        chk("R5 clear flag", longint'(ovf_w), 0);

        // R9: negative saturation
        do_op(C_LOAD, -32768, 32767);
        do_op(C_MAC, -32768, 32767);
        chk("R9 neg word", word_s(), -32768);
        do_op(C_NOP, 0, 0);
        chk("R11 neg flag", longint'(ovf_w), 1);
        do_op(C_CLR, 0, 0);

        // R10: accumulator clamps at its limits
        do_op(C_LOAD, -32768, -32768);
        for (int k = 0; k < 300; k++) do_op(C_MAC, -32768, -32768);
        chk("R10 acc max", acc_s(), 64'sd549755813887);
        chk("R10 flag", longint'(ovf_w), 1);
        for (int k = 0; k < 600; k++) do_op(C_MSU, -32768, -32768);
        chk("R10 acc min", acc_s(), -64'sd549755813888);

        // R1: reset in mid run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 mid acc", acc_s(), 0);
        chk("R1 mid flag", longint'(ovf_w), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule